// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN node is in the bus-off condition and how it gets back to error-active operation. It holds the node's transmit and receive error counters as loaded from a stimulus port, and it moves the node into bus-off as soon as a transmit count above 255 is loaded. While the node is bus-off, the block raises a status flag and a block signal that keeps the node from sending or receiving frames. It then watches the sampled receive line for the recovery sequence.

The recovery sequence is 128 runs, each of 11 consecutive recessive bits. The block counts bits only when the bit-timing logic pulses its per-bit sample strobe. There are two recovery modes, chosen by the auto-recovery bit at the moment bus-off is entered. In automatic mode, counting starts at once. In manual mode, counting stays disabled until software raises the initialization request and then drops it again. When the last bit of the 128th run is sampled, the block clears both error counters and the bus-off flag, and it emits a one-cycle completion pulse.

Top module: `busoff_recovery`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `busOff`, `nodeBlock` and `recoverDone` are 0, and `tecOut` and `recOut` read 0.
- R2: In error-active operation, `errLoad` high at a clock edge copies `tecIn` into `tecOut` and `recIn` into `recOut`, and the new values are visible after that edge.
- R3: A load whose `tecIn` is greater than 255 sets `busOff` at the same edge. A load of 255 or less leaves `busOff` at 0.
- R4: `nodeBlock` is 1 whenever `busOff` is 1. It is also 1 whenever `initReq` is 1, and it is 0 otherwise.
- R5: While `busOff` is 1, `errLoad` has no effect: `tecOut` and `recOut` keep their values.
- R6: While counting is enabled, recovery happens at the edge where the 1408th recessive sample is taken (128 runs × 11 bits, with `rxLevel` = 1 meaning recessive). After 1407 samples the node is still bus-off.
- R7: A dominant sample (`rxLevel` = 0, with the strobe) restarts the current 11-bit run. Runs that were already completed keep counting toward the 128.
- R8: Samples are taken only in cycles where `bitStrobe` is 1. Clock cycles without the strobe do not advance recovery, whatever the level of `rxLevel`.
- R9: If `autoRecover` is 1 at the edge where bus-off is entered, counting is enabled from the next cycle.
- R10: If `autoRecover` is 0 at entry, recessive samples are ignored until `initReq` has been seen at 1 and then at 0. Counting is enabled from the cycle after the edge that sees it at 0.
- R11: On recovery, `busOff` returns to 0, `tecOut` and `recOut` become 0, and `recoverDone` is 1 for exactly one cycle.
- R12: A synchronous reset taken while bus-off returns the block to error-active with the counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| errLoad | input | 1 | Loads the error counters from `tecIn` and `recIn` |
| tecIn | input | TEC_W (9) | Transmit error count to load |
| recIn | input | REC_W (8) | Receive error count to load |
| bitStrobe | input | 1 | One-cycle pulse at each bit sample point |
| rxLevel | input | 1 | Sampled receive level, 1 = recessive |
| autoRecover | input | 1 | Recovery mode bit, 1 = automatic |
| initReq | input | 1 | Initialization-mode request from software |
| busOff | output | 1 | Node is in the bus-off condition |
| nodeBlock | output | 1 | Blocks frame transmission and reception |
| recoverDone | output | 1 | One-cycle pulse when recovery completes |
| tecOut | output | TEC_W (9) | Current transmit error count |
| recOut | output | REC_W (8) | Current receive error count |

## Verification
The assertions check these behaviours on every cycle:
- the block signal covers bus-off;
- loads have no effect while bus-off;
- an over-limit load causes entry into bus-off;
- the completion pulse lasts one cycle, arrives with cleared counters, and follows only a strobed recessive sample.

The exact count of 1408 samples, and the way a dominant sample restarts only the run in progress, can only be shown by the bench's scenarios. The same holds for ignoring clock cycles without a strobe and for gating manual mode behind the initialization trip. Those scenarios sweep the dominant position across a run and the loaded transmit count across the limit.

// File: rtl/busoff_pkg.sv
package busoff_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadErr;     // copy error counters from the inputs
    logic clrErr;      // zero both error counters
    logic clrRun;      // zero the bit and run counters
    logic stepBit;     // one recessive sample taken
    logic restartBit;  // one dominant sample taken
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HOLD   = 2'd1,
    ST_INIT   = 2'd2,
    ST_COUNT  = 2'd3
  } offState_t;

endpackage

// File: rtl/busoff_dp.sv
module busoff_dp
  import busoff_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          ctrl,
  input  logic [TEC_W-1:0] tecIn,
  input  logic [REC_W-1:0] recIn,
  output logic [TEC_W-1:0] tecOut,
  output logic [REC_W-1:0] recOut,
  output logic             bitLast,
  output logic             runLast
);

  localparam int BIT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int RUN_W = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_COUNT - 1);

  logic [TEC_W-1:0] tecReg;
  logic [REC_W-1:0] recReg;
  logic [BIT_W-1:0] bitCnt;
  logic [RUN_W-1:0] runCnt;

  // error counters
  always_ff @(posedge clk) begin
    if (rst || ctrl.clrErr) begin
      tecReg <= '0;
      recReg <= '0;
    end else if (ctrl.loadErr) begin
      tecReg <= tecIn;
      recReg <= recIn;
    end
  end

  // recessive-run counters
  always_ff @(posedge clk) begin
    if (rst || ctrl.clrRun) begin
      bitCnt <= '0;
      runCnt <= '0;
    end else if (ctrl.restartBit) begin
      bitCnt <= '0;
    end else if (ctrl.stepBit) begin
      if (bitLast) begin
        bitCnt <= '0;
        runCnt <= runCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bitLast = (bitCnt == BIT_TOP);
  assign runLast = (runCnt == RUN_TOP);
  assign tecOut  = tecReg;
  assign recOut  = recReg;

endmodule

// File: rtl/busoff_ctrl.sv
module busoff_ctrl
  import busoff_pkg::*;
#(
  parameter int TEC_W = 9,
  parameter int LIMIT = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             errLoad,
  input  logic [TEC_W-1:0] tecIn,
  input  logic             bitStrobe,
  input  logic             rxLevel,
  input  logic             autoRecover,
  input  logic             initReq,
  input  logic             bitLast,
  input  logic             runLast,
  output dpCtrl_t          ctrl,
  output logic             busOff,
  output logic             recoverDone
);

  localparam logic [TEC_W-1:0] TEC_LIMIT = TEC_W'(LIMIT);

  offState_t state, stateNext;
  logic      doneNext;
  logic      doneReg;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_ACTIVE: begin
        ctrl.clrRun = 1'b1;
        if (errLoad) begin
          ctrl.loadErr = 1'b1;
          if (tecIn > TEC_LIMIT)
            stateNext = autoRecover ? ST_COUNT : ST_HOLD;
        end
      end
      ST_HOLD: begin
        ctrl.clrRun = 1'b1;
        if (initReq) stateNext = ST_INIT;
      end
      ST_INIT: begin
        ctrl.clrRun = 1'b1;
        if (!initReq) stateNext = ST_COUNT;
      end
      ST_COUNT: begin
        if (bitStrobe) begin
          if (rxLevel) begin
            ctrl.stepBit = 1'b1;
            if (bitLast && runLast) begin
              ctrl.clrErr = 1'b1;
              ctrl.clrRun = 1'b1;
              doneNext    = 1'b1;
              stateNext   = ST_ACTIVE;
            end
          end else begin
            ctrl.restartBit = 1'b1;
          end
        end
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ACTIVE;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= doneNext;
    end
  end

  assign busOff      = (state != ST_ACTIVE);
  assign recoverDone = doneReg;

endmodule

// File: rtl/busoff_recovery.sv
module busoff_recovery
  import busoff_pkg::*;
#(
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int LIMIT     = 255,
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             errLoad,
  input  logic [TEC_W-1:0] tecIn,
  input  logic [REC_W-1:0] recIn,
  input  logic             bitStrobe,
  input  logic             rxLevel,
  input  logic             autoRecover,
  input  logic             initReq,
  output logic             busOff,
  output logic             nodeBlock,
  output logic             recoverDone,
  output logic [TEC_W-1:0] tecOut,
  output logic [REC_W-1:0] recOut
);

  dpCtrl_t dpCtrl;
  logic    bitLast;
  logic    runLast;

  busoff_ctrl #(
    .TEC_W(TEC_W),
    .LIMIT(LIMIT)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .errLoad    (errLoad),
    .tecIn      (tecIn),
    .bitStrobe  (bitStrobe),
    .rxLevel    (rxLevel),
    .autoRecover(autoRecover),
    .initReq    (initReq),
    .bitLast    (bitLast),
    .runLast    (runLast),
    .ctrl       (dpCtrl),
    .busOff     (busOff),
    .recoverDone(recoverDone)
  );

  busoff_dp #(
    .TEC_W    (TEC_W),
    .REC_W    (REC_W),
    .RUN_LEN  (RUN_LEN),
    .RUN_COUNT(RUN_COUNT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (dpCtrl),
    .tecIn  (tecIn),
    .recIn  (recIn),
    .tecOut (tecOut),
    .recOut (recOut),
    .bitLast(bitLast),
    .runLast(runLast)
  );

  // traffic is halted while bus-off and during initialization
  assign nodeBlock = busOff | initReq;

endmodule

// File: rtl/busoff_recovery_chk.sv
module busoff_recovery_chk #(
  parameter int TEC_W = 9,
  parameter int REC_W = 8,
  parameter int LIMIT = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             errLoad,
  input logic [TEC_W-1:0] tecIn,
  input logic             bitStrobe,
  input logic             rxLevel,
  input logic             busOff,
  input logic             nodeBlock,
  input logic             recoverDone,
  input logic [TEC_W-1:0] tecOut,
  input logic [REC_W-1:0] recOut
);

  localparam logic [TEC_W-1:0] TEC_LIMIT = TEC_W'(LIMIT);

  p_block_covers_r4: assert property (@(posedge clk) disable iff (rst)
    busOff |-> nodeBlock);

  p_frozen_counts_r5: assert property (@(posedge clk) disable iff (rst)
    (busOff && $past(busOff) && !$past(rst)) |-> ($stable(tecOut) && $stable(recOut)));

  p_entry_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!busOff && errLoad && tecIn > TEC_LIMIT) |=> busOff);

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
    recoverDone |=> !recoverDone);

  p_pulse_clears_r11: assert property (@(posedge clk) disable iff (rst)
    recoverDone |-> (!busOff && tecOut == '0 && recOut == '0));

  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (recoverDone && !$past(rst)) |-> ($past(busOff) && $past(bitStrobe) && $past(rxLevel)));

endmodule

bind busoff_recovery busoff_recovery_chk #(
  .TEC_W(TEC_W),
  .REC_W(REC_W),
  .LIMIT(LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .errLoad    (errLoad),
  .tecIn      (tecIn),
  .bitStrobe  (bitStrobe),
  .rxLevel    (rxLevel),
  .busOff     (busOff),
  .nodeBlock  (nodeBlock),
  .recoverDone(recoverDone),
  .tecOut     (tecOut),
  .recOut     (recOut)
);

// File: tb/busoff_recovery_tb.sv
`timescale 1ns/1ps
module busoff_recovery_tb;

  localparam int TEC_W = 9;
  localparam int REC_W = 8;
  localparam int RUN_LEN = 11;
  localparam int RUN_COUNT = 128;
  localparam int TOTAL = RUN_LEN * RUN_COUNT;

  logic             clk = 1'b0;
  logic             rst;
  logic             errLoad;
  logic [TEC_W-1:0] tecIn;
  logic [REC_W-1:0] recIn;
  logic             bitStrobe;
  logic             rxLevel;
  logic             autoRecover;
  logic             initReq;
  logic             busOff;
  logic             nodeBlock;
  logic             recoverDone;
  logic [TEC_W-1:0] tecOut;
  logic [REC_W-1:0] recOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busoff_recovery u_dut (
    .clk(clk), .rst(rst), .errLoad(errLoad), .tecIn(tecIn), .recIn(recIn),
    .bitStrobe(bitStrobe), .rxLevel(rxLevel), .autoRecover(autoRecover),
    .initReq(initReq), .busOff(busOff), .nodeBlock(nodeBlock),
    .recoverDone(recoverDone), .tecOut(tecOut), .recOut(recOut)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic checkEq(input string req, input int actual, input int expected);
    check(actual == expected, req, actual, expected);
  endtask

  task automatic doReset();
    rst = 1'b1; errLoad = 1'b0; tecIn = '0; recIn = '0;
    bitStrobe = 1'b0; rxLevel = 1'b1; initReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input int t, input int r);
    errLoad = 1'b1; tecIn = TEC_W'(t); recIn = REC_W'(r);
    @(negedge clk);
    errLoad = 1'b0;
  endtask

  task automatic sendBits(input int n, input bit lvl);
    for (int i = 0; i < n; i++) begin
      bitStrobe = 1'b1; rxLevel = lvl;
      @(negedge clk);
    end
    bitStrobe = 1'b0; rxLevel = 1'b1;
  endtask

  task automatic checkRecovered(input string req);
    checkEq({req, " busOff cleared"}, int'(busOff), 0);
    checkEq({req, " pulse"}, int'(recoverDone), 1);
    checkEq({req, " tec zero"}, int'(tecOut), 0);
    checkEq({req, " rec zero"}, int'(recOut), 0);
    @(negedge clk);
    checkEq({req, " pulse one cycle"}, int'(recoverDone), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    autoRecover = 1'b1;
    @(negedge clk);
    doReset();
    // R1 reset state
    checkEq("R1 busOff", int'(busOff), 0);
    checkEq("R1 nodeBlock", int'(nodeBlock), 0);
    checkEq("R1 recoverDone", int'(recoverDone), 0);
    checkEq("R1 tec", int'(tecOut), 0);
    checkEq("R1 rec", int'(recOut), 0);

    // R4 init request blocks traffic while error-active
    initReq = 1'b1; #1;
    checkEq("R4 init blocks", int'(nodeBlock), 1);
    initReq = 1'b0; #1;
    checkEq("R4 released", int'(nodeBlock), 0);
    @(negedge clk);

    // R2, R3, R5, R12: sweep of the loaded transmit count across the limit
    for (int t = 250; t <= 262; t++) begin
      doReset();
      load(t, t - 100);
      checkEq("R2 tec load", int'(tecOut), t);
      checkEq("R2 rec load", int'(recOut), t - 100);
      checkEq("R3 entry", int'(busOff), (t > 255) ? 1 : 0);
      checkEq("R4 block", int'(nodeBlock), (t > 255) ? 1 : 0);
      load(7, 9);
      if (t > 255) begin
        checkEq("R5 tec frozen", int'(tecOut), t);
        checkEq("R5 rec frozen", int'(recOut), t - 100);
        doReset();
        checkEq("R12 reset leaves bus-off", int'(busOff), 0);
        checkEq("R12 tec cleared", int'(tecOut), 0);
      end else begin
        checkEq("R2 reload", int'(tecOut), 7);
      end
    end

    // R6, R8, R9, R11: automatic recovery, exact count, gaps without strobe
    doReset();
    autoRecover = 1'b1;
    load(300, 40);
    autoRecover = 1'b0;  // mode was taken at entry
    sendBits(TOTAL - 1, 1'b1);
    checkEq("R6 not yet after 1407", int'(busOff), 1);
    rxLevel = 1'b1;
    repeat (20) @(negedge clk);
    checkEq("R8 no strobe no count", int'(busOff), 1);
    checkEq("R9 auto no pulse yet", int'(recoverDone), 0);
    sendBits(1, 1'b1);
    checkRecovered("R11 auto");

    // R7: dominant sample at several positions inside a run
    for (int p = 0; p < RUN_LEN; p += 5) begin
      doReset();
      autoRecover = 1'b1;
      load(400, 1);
      sendBits(3 * RUN_LEN + p, 1'b1);
      sendBits(1, 1'b0);
      sendBits(TOTAL - 3 * RUN_LEN - 1, 1'b1);
      checkEq("R7 one short after restart", int'(busOff), 1);
      sendBits(1, 1'b1);
      checkRecovered("R7 restart keeps runs");
    end

    // R10: manual mode needs the trip through initialization
    doReset();
    autoRecover = 1'b0;
    load(256, 3);
    sendBits(TOTAL + 10, 1'b1);
    checkEq("R10 ignored before init trip", int'(busOff), 1);
    initReq = 1'b1;
    @(negedge clk);
    checkEq("R4 block in init", int'(nodeBlock), 1);
    sendBits(TOTAL, 1'b1);  // during init, not counted
    checkEq("R10 ignored during init", int'(busOff), 1);
    initReq = 1'b0;
    @(negedge clk);
    sendBits(TOTAL - 1, 1'b1);
    checkEq("R10 not yet", int'(busOff), 1);
    sendBits(1, 1'b1);
    checkRecovered("R10 manual");
    checkEq("R10 back to active", int'(nodeBlock), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule